// File: doc/BRIEF.md
# Edge-Serviced Watchdog Timer

This block watches a processor for signs of life. Software must toggle a single watchdog line at regular intervals; any change of level, rising or falling, counts as service and restarts the timeout count. If the line sits at one level for a full timeout period, the active-low watchdog output drops and stays down until the line is serviced again or the timer is disarmed. The output is meant to drive a non-maskable interrupt, or to be looped back to a manual reset input. A timeout does not reach the system reset by itself.

The timer is disarmed and held clear for as long as system reset is asserted or the watchdog line is flagged as undriven. An undriven line therefore turns the watchdog off, and the output then only reports supply state. Whenever the supply-good flag is false, the output is pulled low at once, with no minimum width. It comes back as soon as the supply recovers, unless the timer has expired. The raw line passes through a synchronizer chain before edge detection. The clock must therefore be fast enough that the shortest service pulse spans at least one clock period.

The control is a three-state machine. **IDLE** means disarmed and cleared. **RUN** means counting. **TRIP** means expired. The transitions are:
- **ARM**: IDLE to RUN, once reset and undriven are both false.
- **SERVICE**: RUN to RUN, on an edge, which clears the count.
- **EXPIRE**: RUN to TRIP, when the count reaches its last value.
- **RECOVER**: TRIP to RUN, on an edge.
- **DISARM**: RUN or TRIP to IDLE, when reset or undriven is seen.

Top module: `wdt_edge_svc`

## Requirements
- R1: While `rst_n` is low, the timer is cleared and `wd_out_n` equals `supply_ok` (high when the supply is good).
- R2: With the line driven, system reset low and no edge, `wd_out_n` stays high for exactly TIMEOUT_CYC rising clock edges after the machine arms, and goes low on the next edge.
- R3: A rising or falling level change on `wd_in` restarts the count. The change clears the counter on the (SYNC_STAGES+1)-th rising edge after it, and a new full period follows from there.
- R4: A high or low pulse on `wd_in` lasting one clock period is seen as service.
- R5: While `wd_undriven` is 1, the count is held at zero and `wd_out_n` is high one edge later, even from the expired state. After it clears, a full period is needed to expire.
- R6: While `sys_reset` is 1, the count is held at zero and the timer cannot expire, even from the expired state. After release, a full period is needed to expire.
- R7: Once expired, `wd_out_n` stays low until an edge is serviced, or until reset or undriven disarms the timer. An edge raises it on the (SYNC_STAGES+1)-th rising edge after the level change.
- R8: When `supply_ok` is 0, `wd_out_n` is 0 in the same cycle, with no minimum pulse width.
- R9: When `supply_ok` returns to 1, `wd_out_n` rises with no added delay if the timer has not expired. Low-line intervals do not alter the timeout count.
- R10: The internal count never exceeds TIMEOUT_CYC-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low flop reset |
| wd_in | input | 1 | Raw watchdog service line, synchronized internally |
| wd_undriven | input | 1 | 1 when the service line is in high impedance; disables the timer |
| sys_reset | input | 1 | 1 while the system reset is asserted; holds the timer clear |
| supply_ok | input | 1 | 0 when the supply is below its threshold |
| wd_out_n | output | 1 | Active-low watchdog output |

## Verification
The main function is tried against several patterns, each of which separates one behaviour from the others:
- A line held at one level measures the exact period to the cycle, which separates a correct count from an off-by-one.
- Steady toggling at half the period shows that both edge polarities are accepted.
- A single-cycle pulse confirms that narrow service is caught by the synchronizer. Expiry is then measured from the pulse's second edge, which tells it apart from a missed pulse.
- Holding reset or undriven for twice the period, and applying them from the expired state, shows disarming is immediate and that a full period follows release.
- Nanosecond low-line glitches placed inside a running period check the combinational override and show the count is undisturbed.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        WD_IDLE = 2'd0,
        WD_RUN  = 2'd1,
        WD_TRIP = 2'd2
    } wd_state_e;

endpackage

// File: rtl/wdt_edge_sense.sv
module wdt_edge_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    output logic line_edge
);
    localparam int LAST_STAGE = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        for (genvar gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[gi] <= 1'b0;
                    else        sync_q[gi] <= line_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[gi] <= 1'b0;
                    else        sync_q[gi] <= sync_q[gi-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[LAST_STAGE];
    end

    assign line_edge = sync_q[LAST_STAGE] ^ prev_q;

endmodule

// File: rtl/wdt_period_count.sv
module wdt_period_count #(
    parameter int TIMEOUT_CYC = 160_000_000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cnt_clr,
    input  logic                           cnt_en,
    output logic [$clog2(TIMEOUT_CYC)-1:0] cnt_q,
    output logic                           at_last
);
    localparam int CW = $clog2(TIMEOUT_CYC);
    localparam logic [CW-1:0] LAST_VAL = CW'(TIMEOUT_CYC - 1);

    assign at_last = (cnt_q == LAST_VAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (cnt_clr)             cnt_q <= '0;
        else if (cnt_en && !at_last)  cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/wdt_ctrl_fsm.sv
module wdt_ctrl_fsm
    import wdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hold,
    input  logic      svc_edge,
    input  logic      at_last,
    input  logic      supply_ok,
    output wd_state_e state_q,
    output logic      cnt_clr,
    output logic      cnt_en,
    output logic      wd_out_n
);
    wd_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE: if (!hold)          state_d = WD_RUN;   // ARM
            WD_RUN: begin
                if (hold)                state_d = WD_IDLE;  // DISARM
                else if (svc_edge)       state_d = WD_RUN;   // SERVICE
                else if (at_last)        state_d = WD_TRIP;  // EXPIRE
            end
            WD_TRIP: begin
                if (hold)                state_d = WD_IDLE;  // DISARM
                else if (svc_edge)       state_d = WD_RUN;   // RECOVER
            end
            default:                     state_d = WD_IDLE;
        endcase
    end

    always_comb begin
        cnt_clr  = hold || svc_edge || (state_q != WD_RUN);
        cnt_en   = (state_q == WD_RUN);
        wd_out_n = supply_ok && (state_q != WD_TRIP);
    end

endmodule

// File: rtl/wdt_edge_svc.sv
module wdt_edge_svc
    import wdt_pkg::*;
#(
    parameter int TIMEOUT_CYC = 160_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wd_in,
    input  logic wd_undriven,
    input  logic sys_reset,
    input  logic supply_ok,
    output logic wd_out_n
);
    localparam int CW = $clog2(TIMEOUT_CYC);

    logic          svc_edge;
    logic          hold;
    logic          cnt_clr;
    logic          cnt_en;
    logic          at_last;
    logic [CW-1:0] cnt_q;
    logic          tripped;
    wd_state_e     state_q;

    assign hold    = sys_reset || wd_undriven;
    assign tripped = (state_q == WD_TRIP);

    wdt_edge_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_raw  (wd_in),
        .line_edge (svc_edge)
    );

    wdt_period_count #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_clr (cnt_clr),
        .cnt_en  (cnt_en),
        .cnt_q   (cnt_q),
        .at_last (at_last)
    );

    wdt_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .svc_edge  (svc_edge),
        .at_last   (at_last),
        .supply_ok (supply_ok),
        .state_q   (state_q),
        .cnt_clr   (cnt_clr),
        .cnt_en    (cnt_en),
        .wd_out_n  (wd_out_n)
    );

endmodule

// File: rtl/wdt_edge_svc_chk.sv
module wdt_edge_svc_chk #(
    parameter int TIMEOUT_CYC = 160_000_000
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           sys_reset,
    input logic                           wd_undriven,
    input logic                           supply_ok,
    input logic                           wd_out_n,
    input logic                           svc_edge,
    input logic                           tripped,
    input logic [$clog2(TIMEOUT_CYC)-1:0] cnt_q
);
    localparam int CW = $clog2(TIMEOUT_CYC);
    localparam logic [CW-1:0] LAST_VAL = CW'(TIMEOUT_CYC - 1);

    // R5 R6
    hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_reset || wd_undriven) |=> (cnt_q == '0 && !tripped));

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_VAL);

    // R3
    svc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_edge |=> (cnt_q == '0 && !tripped));

    // R2
    trip_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tripped) |-> ($past(cnt_q) == LAST_VAL));

    // R7
    trip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tripped && !svc_edge && !sys_reset && !wd_undriven) |=> tripped);

    // R8
    lowline_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |-> !wd_out_n);

endmodule

bind wdt_edge_svc wdt_edge_svc_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sys_reset   (sys_reset),
    .wd_undriven (wd_undriven),
    .supply_ok   (supply_ok),
    .wd_out_n    (wd_out_n),
    .svc_edge    (svc_edge),
    .tripped     (tripped),
    .cnt_q       (cnt_q)
);

// File: tb/wdt_edge_svc_test.sv
module wdt_edge_svc_test;
    localparam int T  = 40;
    localparam int SS = 2;

    logic clk = 1'b0;
    logic rst_n, wd_in, wd_undriven, sys_reset, supply_ok;
    logic wd_out_n;
    int   total = 0;
    int   failed = 0;

    always #5 clk = ~clk;

    wdt_edge_svc #(.TIMEOUT_CYC(T), .SYNC_STAGES(SS)) uut (
        .clk(clk), .rst_n(rst_n), .wd_in(wd_in), .wd_undriven(wd_undriven),
        .sys_reset(sys_reset), .supply_ok(supply_ok), .wd_out_n(wd_out_n)
    );

    task automatic chk(input logic got, input logic exp, input string req);
        total++;
        if (got !== exp) begin
            failed++;
            $display("FAIL %s: wd_out_n=%b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // holds the timer in system reset, then releases it on a falling edge
    task automatic restart();
        sys_reset = 1'b1;
        step(SS + 2);
        sys_reset = 1'b0;
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0; sys_reset = 1'b1; wd_undriven = 1'b0;
        supply_ok = 1'b1; wd_in = 1'b0;
        step(2);
        chk(wd_out_n, 1'b1, "R1 reset output high");
        supply_ok = 1'b0; #1;
        chk(wd_out_n, 1'b0, "R1 reset output follows supply");
        supply_ok = 1'b1;
        step(1);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_timeout();
        restart();
        step(T);
        chk(wd_out_n, 1'b1, "R2 high through full period");
        step(1);
        chk(wd_out_n, 1'b0, "R2 low after period");
    endtask

    task automatic t_trip_sticky();
        step(10);
        chk(wd_out_n, 1'b0, "R7 stays low without service");
        wd_in = ~wd_in;
        step(SS);
        chk(wd_out_n, 1'b0, "R7 still low during sync");
        step(1);
        chk(wd_out_n, 1'b1, "R7 edge releases output");
    endtask

    task automatic t_service();
        restart();
        for (int i = 0; i < 6; i++) begin
            step(T / 2);
            wd_in = ~wd_in;
            chk(wd_out_n, 1'b1, "R3 serviced by toggling");
        end
        step(T + SS);
        chk(wd_out_n, 1'b1, "R3 full period after last edge");
        step(1);
        chk(wd_out_n, 1'b0, "R3 expires after last edge");
    endtask

    task automatic t_pulse();
        restart();
        step(T - 5);
        wd_in = ~wd_in;
        step(1);
        wd_in = ~wd_in;
        step(T + SS);
        chk(wd_out_n, 1'b1, "R4 one-cycle pulse serviced");
        step(1);
        chk(wd_out_n, 1'b0, "R4 expiry measured from pulse end");
    endtask

    task automatic t_undriven();
        wd_undriven = 1'b1;
        step(1);
        chk(wd_out_n, 1'b1, "R5 undriven clears trip");
        step(2 * T);
        chk(wd_out_n, 1'b1, "R5 undriven disables timeout");
        wd_undriven = 1'b0;
        step(T);
        chk(wd_out_n, 1'b1, "R5 full period after undriven");
        step(1);
        chk(wd_out_n, 1'b0, "R5 expires after undriven ends");
    endtask

    task automatic t_sysreset();
        sys_reset = 1'b1;
        step(1);
        chk(wd_out_n, 1'b1, "R6 reset clears trip");
        step(2 * T);
        chk(wd_out_n, 1'b1, "R6 reset holds timer clear");
        sys_reset = 1'b0;
        step(T);
        chk(wd_out_n, 1'b1, "R6 full period after reset");
        step(1);
        chk(wd_out_n, 1'b0, "R6 expires after reset release");
    endtask

    task automatic t_lowline();
        restart();
        step(5);
        #1 supply_ok = 1'b0;
        #1 chk(wd_out_n, 1'b0, "R8 low-line forces low");
        supply_ok = 1'b1;
        #1 chk(wd_out_n, 1'b1, "R9 release without delay");
        step(T - 5);
        chk(wd_out_n, 1'b1, "R9 count unaffected by low-line");
        step(1);
        chk(wd_out_n, 1'b0, "R9 expiry on schedule");
        supply_ok = 1'b0;
        step(1);
        supply_ok = 1'b1;
        #1 chk(wd_out_n, 1'b0, "R9 expired output stays low");
    endtask

    initial begin
        #2_000_000;
        total++; failed++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        t_reset_state();
        t_timeout();
        t_trip_sticky();
        t_service();
        t_pulse();
        t_undriven();
        t_sysreset();
        t_lowline();
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule